// File: doc/BRIEF.md
# Multiphase PWM Fire-Order Sequencer

This block decides which of a pool of physical PWM pins fires on each phase step of a multiphase converter. Every pin holds a small configuration word: whether it is in use, which of two channels (A or B) it belongs to, its phase index inside that channel, and its position in the channel's firing sequence. Each channel has its own slot counter. A tick input for the channel moves the counter on, and the block raises a one-cycle fire pulse on every enabled pin of that channel whose order value equals the slot that was current when the tick arrived.

The sequence follows the programmed order values, not the pin numbers. This lets neighbouring pins on a board be spread apart in time; for example, orders 0-2-4-1-3-5 interleave the pins. An active-phase count per channel sheds phases. The effective phase count is the smallest of three values: the requested count, the number of enabled pins in the channel, and the channel's limit (7 for A, 3 for B). Pins whose order is at or above the effective count are skipped. The highest order values are therefore the first to be dropped and the last to be added back.

Configuration is written through a plain address/data port, one pin per write. The port has no back-pressure: a write is taken in the cycle it is presented, unless conversion is enabled, in which case it is dropped. Tick inputs and outputs are plain control pins, with no handshake.

Top module: `phase_seq_top`

## Requirements
- R1: After reset, every pin's configuration is cleared, so `drive_en` and `fire` are all zero, and ticks cause no fire pulses.
- R2: A configuration word is laid out as follows: bit 7 enable, bit 6 channel (0 = A, 1 = B), bits 5:3 phase index, bits 2:0 fire order. A write with `cfg_we` high stores the word for pin `cfg_addr`, and `drive_en` for that pin shows the enable bit one clock later.
- R3: A write presented while `conv_en` is high leaves the configuration unchanged. Neither `drive_en` nor the fire pattern changes.
- R4: A pin with its enable bit clear keeps `drive_en` low and never fires, even when its order value matches the slot.
- R5: A tick on a channel raises `fire` for exactly one clock, in the cycle after the tick, on each enabled pin of that channel whose order equals the channel's current slot. Successive ticks step through the slots in ascending order, whatever the pin positions.
- R6: The slot counter wraps from the effective count minus one back to 0.
- R7: The effective phase count of a channel is the smallest of three values: the requested active count, the number of enabled pins in the channel, and the channel limit (7 for A, 3 for B).
- R8: A pin whose order is at or above the effective count does not fire (order-based shedding).
- R9: An effective count of 0 produces no fire pulse on that channel and holds its slot at 0.
- R10: Two enabled pins of one channel with the same order value both fire on that slot.
- R11: The two channels count and fire independently, including when both tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_en | input | 1 | Conversion running; blocks configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Pin index of the write |
| cfg_wdata | input | 8 | Configuration word |
| tick_a | input | 1 | Advance channel A slot |
| tick_b | input | 1 | Advance channel B slot |
| active_a | input | 3 | Requested phase count, channel A |
| active_b | input | 3 | Requested phase count, channel B |
| fire | output | 12 | One-cycle fire pulse per pin |
| drive_en | output | 12 | Pin active (1) or tristate (0) |

## Verification
A slot counter holding a wrong value shows up on the first tick that follows: the fire pulse lands on the wrong pin, or on no pin, one clock after that tick. A wrong effective count is not visible right away. It appears only at the wrap point, where a shed pin fires or the sequence returns to order 0 too early, so the bench runs each channel through a full cycle and past the wrap. A corrupted configuration word shows on `drive_en` one clock after the write.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;
  localparam int ORDW = 3;
  localparam int IDXW = 3;
  localparam int CFGW = 2 + IDXW + ORDW;

  typedef struct packed {
    logic            en;
    logic            chan;
    logic [IDXW-1:0] idx;
    logic [ORDW-1:0] ord;
  } pin_cfg_t;
endpackage

// File: rtl/phase_cfg_regs.sv
module phase_cfg_regs
  import phase_seq_pkg::*;
#(
  parameter int NPINS = 12,
  parameter int ADDRW = 4,
  parameter int CNTW  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  conv_en,
  input  logic                  we,
  input  logic [ADDRW-1:0]      addr,
  input  logic [CFGW-1:0]       wdata,
  output pin_cfg_t [NPINS-1:0]  cfg_q,
  output logic [CNTW-1:0]       cnt_a,
  output logic [CNTW-1:0]       cnt_b
);
  logic wr_ok;
  assign wr_ok = we && !conv_en && (int'(addr) < NPINS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_ok) begin
      cfg_q[addr] <= pin_cfg_t'(wdata);
    end
  end

  always_comb begin
    cnt_a = '0;
    cnt_b = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (cfg_q[p].en && !cfg_q[p].chan) cnt_a = cnt_a + CNTW'(1);
      if (cfg_q[p].en &&  cfg_q[p].chan) cnt_b = cnt_b + CNTW'(1);
    end
  end

  // R3
  write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && we) |=> $stable(cfg_q));

  // R2
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok) |=> (cfg_q[$past(addr)] == pin_cfg_t'($past(wdata))));
endmodule

// File: rtl/phase_slot_ctr.sv
module phase_slot_ctr #(
  parameter int MAXPH = 7,
  parameter int ACTW  = 3,
  parameter int CNTW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [ACTW-1:0] active_req,
  input  logic [CNTW-1:0] enabled_cnt,
  output logic [CNTW-1:0] slot_q,
  output logic [CNTW-1:0] eff
);
  localparam logic [CNTW-1:0] MAXC = CNTW'(MAXPH);

  always_comb begin
    eff = CNTW'(active_req);
    if (enabled_cnt < eff) eff = enabled_cnt;
    if (MAXC < eff)        eff = MAXC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (eff == '0) begin
      slot_q <= '0;
    end else if (tick) begin
      if (slot_q >= eff - CNTW'(1)) slot_q <= '0;
      else                          slot_q <= slot_q + CNTW'(1);
    end
  end

  // R6
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && eff != '0) |=> (slot_q < $past(eff)));

  // R7
  eff_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff <= MAXC) && (eff <= enabled_cnt));

  // R9
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff == '0) |=> (slot_q == '0));
endmodule

// File: rtl/phase_fire_match.sv
module phase_fire_match
  import phase_seq_pkg::*;
#(
  parameter int NPINS = 12,
  parameter int CNTW  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pin_cfg_t [NPINS-1:0] cfg,
  input  logic                 tick_a,
  input  logic                 tick_b,
  input  logic [CNTW-1:0]      slot_a,
  input  logic [CNTW-1:0]      slot_b,
  input  logic [CNTW-1:0]      eff_a,
  input  logic [CNTW-1:0]      eff_b,
  output logic [NPINS-1:0]     fire_q
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic            hit;
    logic [CNTW-1:0] ordx;
    assign ordx = CNTW'(cfg[p].ord);
    always_comb begin
      if (cfg[p].chan) hit = tick_b && (ordx == slot_b) && (ordx < eff_b);
      else             hit = tick_a && (ordx == slot_a) && (ordx < eff_a);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) fire_q[p] <= 1'b0;
      else        fire_q[p] <= cfg[p].en && hit;
    end

    // R4
    fire_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_q[p] |-> $past(cfg[p].en));

    // R5
    fire_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_q[p] |-> ($past(cfg[p].chan) ? $past(tick_b) : $past(tick_a)));
  end
endmodule

// File: rtl/phase_seq_top.sv
module phase_seq_top
  import phase_seq_pkg::*;
#(
  parameter int NPINS = 12,
  parameter int A_MAX = 7,
  parameter int B_MAX = 3,
  parameter int ACTW  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       conv_en,
  input  logic                       cfg_we,
  input  logic [$clog2(NPINS)-1:0]   cfg_addr,
  input  logic [7:0]                 cfg_wdata,
  input  logic                       tick_a,
  input  logic                       tick_b,
  input  logic [ACTW-1:0]            active_a,
  input  logic [ACTW-1:0]            active_b,
  output logic [NPINS-1:0]           fire,
  output logic [NPINS-1:0]           drive_en
);
  localparam int ADDRW = $clog2(NPINS);
  localparam int CNTW  = $clog2(NPINS + 1);

  pin_cfg_t [NPINS-1:0] cfg_q;
  logic [CNTW-1:0] cnt_a, cnt_b, slot_a, slot_b, eff_a, eff_b;

  phase_cfg_regs #(.NPINS(NPINS), .ADDRW(ADDRW), .CNTW(CNTW)) regs_i (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .we(cfg_we),
    .addr(cfg_addr), .wdata(cfg_wdata[CFGW-1:0]), .cfg_q(cfg_q),
    .cnt_a(cnt_a), .cnt_b(cnt_b)
  );

  phase_slot_ctr #(.MAXPH(A_MAX), .ACTW(ACTW), .CNTW(CNTW)) ctr_a_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_a), .active_req(active_a),
    .enabled_cnt(cnt_a), .slot_q(slot_a), .eff(eff_a)
  );

  phase_slot_ctr #(.MAXPH(B_MAX), .ACTW(ACTW), .CNTW(CNTW)) ctr_b_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_b), .active_req(active_b),
    .enabled_cnt(cnt_b), .slot_q(slot_b), .eff(eff_b)
  );

  phase_fire_match #(.NPINS(NPINS), .CNTW(CNTW)) match_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .tick_a(tick_a), .tick_b(tick_b),
    .slot_a(slot_a), .slot_b(slot_b), .eff_a(eff_a), .eff_b(eff_b),
    .fire_q(fire)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_drv
    assign drive_en[p] = cfg_q[p].en;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (fire == '0 && drive_en == '0));
endmodule

// File: tb/phase_seq_top_tb.sv
module phase_seq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_en = 1'b0, cfg_we = 1'b0, tick_a = 1'b0, tick_b = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [2:0] active_a = '0, active_b = '0;
  logic [11:0] fire, drive_en;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  phase_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .tick_a(tick_a), .tick_b(tick_b),
    .active_a(active_a), .active_b(active_b), .fire(fire), .drive_en(drive_en)
  );

  function automatic logic [7:0] word(bit en, bit ch, int idx, int ord);
    return {en, ch, 3'(idx), 3'(ord)};
  endfunction

  task automatic chk(string req, logic [11:0] got, logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; conv_en = 0; cfg_we = 0; tick_a = 0; tick_b = 0;
    active_a = 0; active_b = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(int addr, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(addr); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic tk(bit a, bit b, string req, logic [11:0] exp);
    @(negedge clk);
    tick_a = a; tick_b = b;
    @(negedge clk);
    tick_a = 0; tick_b = 0;
    chk(req, fire, exp);
  endtask

  task automatic t_reset();
    do_reset();
    active_a = 7; active_b = 7;
    chk("R1 drive_en", drive_en, 12'h000);
    tk(1, 1, "R1 fire", 12'h000);
  endtask

  task automatic t_example();
    do_reset();
    wr(0, word(1, 0, 0, 0));
    wr(1, word(1, 0, 1, 2));
    wr(2, word(1, 0, 2, 1));
    wr(5, word(1, 1, 1, 1));
    wr(6, word(1, 1, 0, 0));
    chk("R2 drive_en", drive_en, 12'h067);
    active_a = 7; active_b = 3;
    tk(1, 1, "R11 slot0 both", 12'h041);
    tk(1, 1, "R5 R11 slot1 both", 12'h024);
    tk(1, 0, "R5 A order2", 12'h002);
    @(negedge clk);
    chk("R5 pulse clears", fire, 12'h000);
    tk(1, 0, "R6 A wrap", 12'h001);
    tk(0, 1, "R6 B wrap", 12'h040);
  endtask

  task automatic t_shed();
    do_reset();
    wr(0, word(1, 0, 0, 0));
    wr(1, word(1, 0, 1, 2));
    wr(2, word(1, 0, 2, 1));
    active_a = 2;
    tk(1, 0, "R8 shed s0", 12'h001);
    tk(1, 0, "R8 shed s1", 12'h004);
    tk(1, 0, "R8 order2 shed", 12'h001);
    active_a = 0;
    tk(1, 0, "R9 zero count", 12'h000);
    active_a = 1;
    tk(1, 0, "R9 restart", 12'h001);
    tk(1, 0, "R6 single", 12'h001);
  endtask

  task automatic t_lock();
    do_reset();
    active_a = 7;
    conv_en = 1;
    wr(3, word(1, 0, 0, 0));
    chk("R3 locked drive_en", drive_en, 12'h000);
    tk(1, 0, "R3 locked fire", 12'h000);
    conv_en = 0;
    wr(3, word(1, 0, 0, 0));
    chk("R2 unlocked drive_en", drive_en, 12'h008);
    tk(1, 0, "R2 unlocked fire", 12'h008);
  endtask

  task automatic t_dup();
    do_reset();
    wr(0, word(1, 0, 0, 0));
    wr(7, word(1, 0, 1, 0));
    wr(4, word(0, 0, 2, 0));
    chk("R4 drive_en", drive_en, 12'h081);
    active_a = 7;
    tk(1, 0, "R10 R4 dup", 12'h081);
    tk(1, 0, "R7 clamp slot1", 12'h000);
    tk(1, 0, "R7 clamp wrap", 12'h081);
  endtask

  task automatic t_bmax();
    do_reset();
    for (int i = 0; i < 4; i++) wr(8 + i, word(1, 1, i, i));
    active_b = 7;
    tk(0, 1, "R7 B s0", 12'h100);
    tk(0, 1, "R7 B s1", 12'h200);
    tk(0, 1, "R7 B s2", 12'h400);
    tk(0, 1, "R7 B limit wrap", 12'h100);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_example();
    t_shed();
    t_lock();
    t_dup();
    t_bmax();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule